// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block sits between two chained interrupt controllers and the processor. The second controller feeds the first one through its line 2. The block does not arbitrate priority itself. Each controller's priority resolver gives it a winning line and a valid flag. From these, and from each controller's vector base, end-of-interrupt mode and trigger modes, the block does three things:

- It drives the processor's interrupt line.
- It forwards the second controller's request into the first one as a short pulse.
- When the processor acknowledges, it produces the 8-bit vector and the one-cycle update strobes for each controller's in-service, pending and priority-base registers.

An acknowledge strobe sampled on a clock edge gives a registered vector and registered strobes in the next cycle. The controller register files apply the strobes on that cycle's closing edge. Their resolvers then present fresh winners, and the interrupt output follows those winners one clock later. A vector base is expected to have its three low bits at zero; the vector is the base plus the line number. A level mask bit of 1 marks that line as level-triggered; 0 marks it as edge-triggered.

Top module: `casc_ack_seq`

## Requirements
- R1: `casc_pulse` in a cycle equals `slv_win_vld` AND NOT `casc_pulse` of the previous cycle. While the slave resolver holds a winner, the pulse therefore alternates high and low, and it is never high in two consecutive cycles.
- R2: `cpu_irq` in each cycle equals `mst_win_vld` of the previous cycle.
- R3: `vec_vld` is high in exactly the cycle after `ack_req` was sampled high. All set, clear and load strobes are zero in every cycle where `vec_vld` is low.
- R4: On acknowledge, when the master has a winner on a line other than 2, `vec_out` = `mst_vec_base` + line, and no slave strobe fires.
- R5: On acknowledge, when the master has no winner, `vec_out` = `mst_vec_base` + 7, and every strobe stays zero.
- R6: On acknowledge, when the master winner is line 2 and the slave has a winner, `vec_out` = `slv_vec_base` + slave line, and both controllers are acknowledged (master on line 2, slave on its line).
- R7: On acknowledge, when the master winner is line 2 and the slave has no winner, `vec_out` = `slv_vec_base` + 7. Only the master is acknowledged, and all slave strobes stay zero.
- R8: For an acknowledged controller, the pending-clear strobe has a single bit set at the acknowledged line if that line's level mask bit is 0 (edge). It is all zero if that bit is 1 (level).
- R9: For an acknowledged controller with auto-EOI off, the in-service set strobe has a single bit set at the acknowledged line, and the priority load stays low.
- R10: For an acknowledged controller with auto-EOI on and rotate off, the in-service set strobe is zero and the priority load stays low.
- R11: For an acknowledged controller with auto-EOI and rotate both on, the priority load is high and the new priority base is (line + 1) mod 8, so line 7 gives 0. The in-service set strobe is zero.
- R12: During and directly after synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_win_vld | input | 1 | Master resolver has a winner |
| mst_win_line | input | 3 | Master winning line |
| slv_win_vld | input | 1 | Slave resolver has a winner |
| slv_win_line | input | 3 | Slave winning line |
| mst_vec_base | input | 8 | Master vector base |
| slv_vec_base | input | 8 | Slave vector base |
| mst_auto_eoi | input | 1 | Master automatic end-of-interrupt |
| mst_rot_aeoi | input | 1 | Master rotate on automatic end-of-interrupt |
| slv_auto_eoi | input | 1 | Slave automatic end-of-interrupt |
| slv_rot_aeoi | input | 1 | Slave rotate on automatic end-of-interrupt |
| mst_level_mask | input | 8 | Master level-trigger mask (1 = level) |
| slv_level_mask | input | 8 | Slave level-trigger mask (1 = level) |
| ack_req | input | 1 | Processor acknowledge strobe |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Acknowledged vector |
| vec_vld | output | 1 | Vector valid, one cycle |
| casc_pulse | output | 1 | Pulse into master line 2 |
| mst_isr_set | output | 8 | Master in-service set strobe |
| mst_irr_clr | output | 8 | Master pending clear strobe |
| mst_prio_load | output | 1 | Master priority base load |
| mst_prio_base | output | 3 | Master new priority base |
| slv_isr_set | output | 8 | Slave in-service set strobe |
| slv_irr_clr | output | 8 | Slave pending clear strobe |
| slv_prio_load | output | 1 | Slave priority base load |
| slv_prio_base | output | 3 | Slave new priority base |

## Verification
The bench acknowledges while the master has no winner, which must give base + 7 with no strobes. A design that acknowledged anyway would set a stray in-service bit. It acknowledges on line 2 with and without a slave winner. A design that mixed up the two cases would return a master vector, or would clear a slave line that never won. It checks line 7 with rotation, where a missing wrap would load 8 truncated wrongly or load nothing, and a level-triggered line whose pending bit must survive. It also holds the slave request for several cycles to confirm the forwarded pulse re-arms every other cycle instead of sticking high, which the master's edge detector would see as only one edge.

// File: rtl/casc_pkg.sv
// Shared types for the cascaded acknowledge sequencer.
// Assumes: two controller levels, index 0 master and index 1 slave.
package casc_pkg;

    // Where the acknowledged vector comes from.
    typedef enum logic [1:0] {
        SRC_MST      = 2'd0,
        SRC_SLV      = 2'd1,
        SRC_MST_SPUR = 2'd2,
        SRC_SLV_SPUR = 2'd3
    } vec_src_e;

    localparam int NUM_LEVELS = 2;
    localparam int LVL_MST    = 0;
    localparam int LVL_SLV    = 1;

endpackage

// File: rtl/casc_fwd.sv
// Cascade forwarder: turns a held slave request into a train of one-cycle
// pulses on master line 2. Each pulse is followed by a low cycle, so an
// edge detector in the master sees a fresh rising edge each time.
// Assumes: slv_win_vld is synchronous to clk.
module casc_fwd (
    input  logic clk,
    input  logic rst_n,
    input  logic slv_win_vld,
    output logic casc_pulse
);

    // Raise the pulse when the slave wins and the pulse was low last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) casc_pulse <= 1'b0;
        else        casc_pulse <= slv_win_vld && !casc_pulse;
    end

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        casc_pulse |=> !casc_pulse); // R1
    AST_PULSE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        casc_pulse |-> $past(slv_win_vld)); // R1

endmodule

// File: rtl/casc_vec_sel.sv
// Vector selector: decides which controller supplies the vector at
// acknowledge, substitutes the spurious line where a level has no winner,
// and registers the vector with its valid flag. It also gives out the
// per-level acknowledge enables.
// Assumes: the bases carry zeros in their low line-number bits.
module casc_vec_sel
    import casc_pkg::*;
#(
    parameter int LINES     = 8,
    parameter int LW        = 3,
    parameter int VEC_W     = 8,
    parameter int CASC_LINE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic             mst_win_vld,
    input  logic [LW-1:0]    mst_win_line,
    input  logic             slv_win_vld,
    input  logic [LW-1:0]    slv_win_line,
    input  logic [VEC_W-1:0] mst_vec_base,
    input  logic [VEC_W-1:0] slv_vec_base,
    output logic             mst_fire,
    output logic             slv_fire,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_vld
);

    localparam logic [LW-1:0] SPUR_LINE = LW'(LINES - 1);
    localparam logic [LW-1:0] CASC_IDX  = LW'(CASC_LINE);

    logic            casc_hit;
    vec_src_e        src;
    logic [VEC_W-1:0] vec_nxt;

    // Classify the acknowledge by which level owns it.
    always_comb begin
        casc_hit = mst_win_vld && (mst_win_line == CASC_IDX);
        if (!mst_win_vld)     src = SRC_MST_SPUR;
        else if (!casc_hit)   src = SRC_MST;
        else if (slv_win_vld) src = SRC_SLV;
        else                  src = SRC_SLV_SPUR;
    end

    // Acknowledge enables for each level.
    assign mst_fire = ack_req && mst_win_vld;
    assign slv_fire = ack_req && (src == SRC_SLV);

    // Form the vector as base plus line, spurious line where needed.
    always_comb begin
        unique case (src)
            SRC_MST:      vec_nxt = mst_vec_base + VEC_W'(mst_win_line);
            SRC_SLV:      vec_nxt = slv_vec_base + VEC_W'(slv_win_line);
            SRC_SLV_SPUR: vec_nxt = slv_vec_base + VEC_W'(SPUR_LINE);
            default:      vec_nxt = mst_vec_base + VEC_W'(SPUR_LINE);
        endcase
    end

    // Register the vector for one cycle after the acknowledge strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= ack_req;
            vec_out <= ack_req ? vec_nxt : '0;
        end
    end

    AST_VLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> vec_vld); // R3
    AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !vec_vld); // R3
    AST_SLV_NEEDS_MST: assert property (@(posedge clk) disable iff (!rst_n)
        slv_fire |-> mst_fire); // R6

endmodule

// File: rtl/casc_ack_unit.sv
// Per-level acknowledge action: for one controller, turns an acknowledge
// of a line into registered one-cycle strobes. The strobes are an
// in-service set, a pending clear (edge lines only) and a priority-base
// load (rotate on auto-EOI).
// Assumes: fire and line are stable in the cycle they are sampled.
module casc_ack_unit #(
    parameter int LINES = 8,
    parameter int LW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LW-1:0]    line,
    input  logic             auto_eoi,
    input  logic             rot_aeoi,
    input  logic [LINES-1:0] level_mask,
    output logic [LINES-1:0] isr_set,
    output logic [LINES-1:0] irr_clr,
    output logic             prio_load,
    output logic [LW-1:0]    prio_base
);

    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    logic [LINES-1:0] line_bit;
    logic [LW-1:0]    next_base;

    // Decode the acknowledged line and its successor in rotation order.
    always_comb begin
        line_bit  = LINES'(1) << line;
        next_base = (line == LAST_LINE) ? '0 : line + LW'(1);
    end

    // Register the strobes; they are zero except in the cycle after fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_set   <= '0;
            irr_clr   <= '0;
            prio_load <= 1'b0;
            prio_base <= '0;
        end else begin
            isr_set   <= (fire && !auto_eoi) ? line_bit : '0;
            irr_clr   <= fire ? (line_bit & ~level_mask) : '0;
            prio_load <= fire && auto_eoi && rot_aeoi;
            prio_base <= (fire && auto_eoi && rot_aeoi) ? next_base : '0;
        end
    end

    AST_ISR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_set)); // R9
    AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && auto_eoi) |=> (isr_set == '0)); // R10
    AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((irr_clr & $past(level_mask)) == '0)); // R8
    AST_ROT_ONLY_AEOI: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !auto_eoi) |=> !prio_load); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (isr_set == '0 && irr_clr == '0 && !prio_load)); // R3

endmodule

// File: rtl/casc_ack_seq.sv
// Cascaded interrupt acknowledge sequencer (top). Drives the processor
// interrupt line, forwards slave requests into master line 2, and on
// acknowledge returns the vector and the update strobes for both levels.
// Assumes: resolver outputs reflect the controllers' current state and
// the register files apply the strobes on the cycle they are presented.
module casc_ack_seq
    import casc_pkg::*;
#(
    parameter int LINES     = 8,
    parameter int VEC_W     = 8,
    parameter int CASC_LINE = 2,
    localparam int LW       = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mst_win_vld,
    input  logic [LW-1:0]    mst_win_line,
    input  logic             slv_win_vld,
    input  logic [LW-1:0]    slv_win_line,
    input  logic [VEC_W-1:0] mst_vec_base,
    input  logic [VEC_W-1:0] slv_vec_base,
    input  logic             mst_auto_eoi,
    input  logic             mst_rot_aeoi,
    input  logic             slv_auto_eoi,
    input  logic             slv_rot_aeoi,
    input  logic [LINES-1:0] mst_level_mask,
    input  logic [LINES-1:0] slv_level_mask,
    input  logic             ack_req,
    output logic             cpu_irq,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_vld,
    output logic             casc_pulse,
    output logic [LINES-1:0] mst_isr_set,
    output logic [LINES-1:0] mst_irr_clr,
    output logic             mst_prio_load,
    output logic [LW-1:0]    mst_prio_base,
    output logic [LINES-1:0] slv_isr_set,
    output logic [LINES-1:0] slv_irr_clr,
    output logic             slv_prio_load,
    output logic [LW-1:0]    slv_prio_base
);

    logic                   mst_fire;
    logic                   slv_fire;

    logic [NUM_LEVELS-1:0]  lv_fire;
    logic [NUM_LEVELS-1:0]  lv_aeoi;
    logic [NUM_LEVELS-1:0]  lv_rot;
    logic [NUM_LEVELS-1:0]  lv_pload;
    logic [LW-1:0]          lv_line  [NUM_LEVELS];
    logic [LW-1:0]          lv_pbase [NUM_LEVELS];
    logic [LINES-1:0]       lv_lmask [NUM_LEVELS];
    logic [LINES-1:0]       lv_isr   [NUM_LEVELS];
    logic [LINES-1:0]       lv_irr   [NUM_LEVELS];

    // Track the master winner onto the processor interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= mst_win_vld;
    end

    casc_fwd u_fwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .slv_win_vld (slv_win_vld),
        .casc_pulse  (casc_pulse)
    );

    casc_vec_sel #(
        .LINES     (LINES),
        .LW        (LW),
        .VEC_W     (VEC_W),
        .CASC_LINE (CASC_LINE)
    ) u_vsel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_req      (ack_req),
        .mst_win_vld  (mst_win_vld),
        .mst_win_line (mst_win_line),
        .slv_win_vld  (slv_win_vld),
        .slv_win_line (slv_win_line),
        .mst_vec_base (mst_vec_base),
        .slv_vec_base (slv_vec_base),
        .mst_fire     (mst_fire),
        .slv_fire     (slv_fire),
        .vec_out      (vec_out),
        .vec_vld      (vec_vld)
    );

    // Gather each level's controls into indexed form.
    assign lv_fire[LVL_MST]  = mst_fire;
    assign lv_fire[LVL_SLV]  = slv_fire;
    assign lv_aeoi[LVL_MST]  = mst_auto_eoi;
    assign lv_aeoi[LVL_SLV]  = slv_auto_eoi;
    assign lv_rot[LVL_MST]   = mst_rot_aeoi;
    assign lv_rot[LVL_SLV]   = slv_rot_aeoi;
    assign lv_line[LVL_MST]  = mst_win_line;
    assign lv_line[LVL_SLV]  = slv_win_line;
    assign lv_lmask[LVL_MST] = mst_level_mask;
    assign lv_lmask[LVL_SLV] = slv_level_mask;

    // One acknowledge action unit for each controller level.
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        casc_ack_unit #(
            .LINES (LINES),
            .LW    (LW)
        ) u_ack (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (lv_fire[g]),
            .line       (lv_line[g]),
            .auto_eoi   (lv_aeoi[g]),
            .rot_aeoi   (lv_rot[g]),
            .level_mask (lv_lmask[g]),
            .isr_set    (lv_isr[g]),
            .irr_clr    (lv_irr[g]),
            .prio_load  (lv_pload[g]),
            .prio_base  (lv_pbase[g])
        );
    end

    // Spread indexed results back onto the named ports.
    assign mst_isr_set   = lv_isr[LVL_MST];
    assign mst_irr_clr   = lv_irr[LVL_MST];
    assign mst_prio_load = lv_pload[LVL_MST];
    assign mst_prio_base = lv_pbase[LVL_MST];
    assign slv_isr_set   = lv_isr[LVL_SLV];
    assign slv_irr_clr   = lv_irr[LVL_SLV];
    assign slv_prio_load = lv_pload[LVL_SLV];
    assign slv_prio_base = lv_pbase[LVL_SLV];

    AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cpu_irq == $past(mst_win_vld))); // R2
    AST_STROBE_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_isr_set != '0 || slv_isr_set != '0 || mst_prio_load
         || slv_prio_load) |-> vec_vld); // R3
    AST_SLV_NEEDS_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_isr_set != '0 || slv_irr_clr != '0 || slv_prio_load)
        |-> $past(mst_win_line == LW'(CASC_LINE))); // R6

endmodule

// File: tb/casc_ack_seq_test.sv
// Directed bench: one task per scenario, inputs driven on the falling
// edge, outputs sampled 1 ns after the rising edge.
module casc_ack_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mst_win_vld, slv_win_vld;
    logic [2:0] mst_win_line, slv_win_line;
    logic [7:0] mst_vec_base, slv_vec_base;
    logic       mst_auto_eoi, mst_rot_aeoi, slv_auto_eoi, slv_rot_aeoi;
    logic [7:0] mst_level_mask, slv_level_mask;
    logic       ack_req;
    logic       cpu_irq, vec_vld, casc_pulse;
    logic [7:0] vec_out, mst_isr_set, mst_irr_clr, slv_isr_set, slv_irr_clr;
    logic       mst_prio_load, slv_prio_load;
    logic [2:0] mst_prio_base, slv_prio_base;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    casc_ack_seq uut (
        .clk(clk), .rst_n(rst_n),
        .mst_win_vld(mst_win_vld), .mst_win_line(mst_win_line),
        .slv_win_vld(slv_win_vld), .slv_win_line(slv_win_line),
        .mst_vec_base(mst_vec_base), .slv_vec_base(slv_vec_base),
        .mst_auto_eoi(mst_auto_eoi), .mst_rot_aeoi(mst_rot_aeoi),
        .slv_auto_eoi(slv_auto_eoi), .slv_rot_aeoi(slv_rot_aeoi),
        .mst_level_mask(mst_level_mask), .slv_level_mask(slv_level_mask),
        .ack_req(ack_req), .cpu_irq(cpu_irq), .vec_out(vec_out),
        .vec_vld(vec_vld), .casc_pulse(casc_pulse),
        .mst_isr_set(mst_isr_set), .mst_irr_clr(mst_irr_clr),
        .mst_prio_load(mst_prio_load), .mst_prio_base(mst_prio_base),
        .slv_isr_set(slv_isr_set), .slv_irr_clr(slv_irr_clr),
        .slv_prio_load(slv_prio_load), .slv_prio_base(slv_prio_base)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        mst_win_vld = 0; mst_win_line = 0; slv_win_vld = 0; slv_win_line = 0;
        mst_vec_base = 8'h20; slv_vec_base = 8'h70;
        mst_auto_eoi = 0; mst_rot_aeoi = 0; slv_auto_eoi = 0; slv_rot_aeoi = 0;
        mst_level_mask = 0; slv_level_mask = 0; ack_req = 0;
    endtask

    // Pulse ack_req for one cycle; returns with registered results visible.
    task automatic do_ack();
        @(negedge clk);
        ack_req = 1'b1;
        tick();
    endtask

    // Release the acknowledge and confirm the outputs go quiet.
    task automatic end_ack(input string req);
        @(negedge clk);
        ack_req = 1'b0;
        tick();
        chk(req, "vec_vld after", vec_vld, 0);
        chk(req, "mst_isr after", mst_isr_set, 0);
        chk(req, "slv_isr after", slv_isr_set, 0);
    endtask

    task automatic t_reset();
        idle_inputs();
        mst_win_vld = 1; slv_win_vld = 1; ack_req = 1;
        rst_n = 0;
        repeat (3) tick();
        chk("R12", "cpu_irq", cpu_irq, 0);
        chk("R12", "vec_vld", vec_vld, 0);
        chk("R12", "casc_pulse", casc_pulse, 0);
        chk("R12", "strobes", {mst_isr_set, mst_irr_clr, slv_isr_set, slv_irr_clr}, 0);
        @(negedge clk);
        idle_inputs();
        rst_n = 1;
        tick();
        chk("R12", "vec_vld post", vec_vld, 0);
    endtask

    task automatic t_irq();
        @(negedge clk); mst_win_vld = 1; mst_win_line = 4;
        chk("R2", "irq before edge", cpu_irq, 0);
        tick();
        chk("R2", "irq raised", cpu_irq, 1);
        @(negedge clk); mst_win_vld = 0;
        tick();
        chk("R2", "irq dropped", cpu_irq, 0);
    endtask

    task automatic t_pulse();
        @(negedge clk); slv_win_vld = 1;
        tick(); chk("R1", "pulse 1", casc_pulse, 1);
        tick(); chk("R1", "gap 1", casc_pulse, 0);
        tick(); chk("R1", "pulse 2", casc_pulse, 1);
        @(negedge clk); slv_win_vld = 0;
        tick(); chk("R1", "after drop a", casc_pulse, 0);
        tick(); chk("R1", "after drop b", casc_pulse, 0);
    endtask

    task automatic t_plain();
        @(negedge clk); mst_win_vld = 1; mst_win_line = 5;
        do_ack();
        chk("R3", "vec_vld", vec_vld, 1);
        chk("R4", "vector", vec_out, 8'h25);
        chk("R9", "mst_isr", mst_isr_set, 8'h20);
        chk("R8", "mst_irr edge", mst_irr_clr, 8'h20);
        chk("R9", "no prio load", mst_prio_load, 0);
        chk("R4", "slv quiet", {slv_isr_set, slv_irr_clr}, 0);
        end_ack("R3");
    endtask

    task automatic t_level();
        @(negedge clk); mst_win_vld = 1; mst_win_line = 6; mst_level_mask = 8'h40;
        do_ack();
        chk("R4", "vector", vec_out, 8'h26);
        chk("R8", "mst_irr level kept", mst_irr_clr, 0);
        chk("R9", "mst_isr", mst_isr_set, 8'h40);
        end_ack("R8");
        mst_level_mask = 0;
    endtask

    task automatic t_mst_spur();
        @(negedge clk); mst_win_vld = 0; mst_win_line = 3;
        do_ack();
        chk("R5", "vec_vld", vec_vld, 1);
        chk("R5", "vector", vec_out, 8'h27);
        chk("R5", "strobes", {mst_isr_set, mst_irr_clr, slv_isr_set, slv_irr_clr}, 0);
        chk("R5", "loads", {mst_prio_load, slv_prio_load}, 0);
        end_ack("R5");
    endtask

    task automatic t_cascade();
        @(negedge clk); mst_win_vld = 1; mst_win_line = 2;
        slv_win_vld = 1; slv_win_line = 3;
        do_ack();
        chk("R6", "vector", vec_out, 8'h73);
        chk("R6", "mst_isr", mst_isr_set, 8'h04);
        chk("R6", "mst_irr", mst_irr_clr, 8'h04);
        chk("R6", "slv_isr", slv_isr_set, 8'h08);
        chk("R6", "slv_irr", slv_irr_clr, 8'h08);
        end_ack("R6");
        slv_win_vld = 0;
    endtask

    task automatic t_casc_spur();
        @(negedge clk); mst_win_vld = 1; mst_win_line = 2;
        slv_win_vld = 0; slv_win_line = 3;
        do_ack();
        chk("R7", "vector", vec_out, 8'h77);
        chk("R7", "mst_isr", mst_isr_set, 8'h04);
        chk("R7", "slv quiet", {slv_isr_set, slv_irr_clr}, 0);
        chk("R7", "slv load", slv_prio_load, 0);
        end_ack("R7");
    endtask

    task automatic t_aeoi();
        @(negedge clk); mst_win_vld = 1; mst_win_line = 1; mst_auto_eoi = 1;
        do_ack();
        chk("R10", "vector", vec_out, 8'h21);
        chk("R10", "no isr", mst_isr_set, 0);
        chk("R10", "irr still cleared", mst_irr_clr, 8'h02);
        chk("R10", "no load", mst_prio_load, 0);
        end_ack("R10");
        mst_auto_eoi = 0;
    endtask

    task automatic t_rotate();
        @(negedge clk); mst_win_vld = 1; mst_win_line = 7;
        mst_auto_eoi = 1; mst_rot_aeoi = 1;
        do_ack();
        chk("R11", "load", mst_prio_load, 1);
        chk("R11", "wrap base", mst_prio_base, 0);
        chk("R11", "no isr", mst_isr_set, 0);
        end_ack("R11");
        @(negedge clk); mst_win_line = 2; mst_auto_eoi = 0; mst_rot_aeoi = 0;
        slv_win_vld = 1; slv_win_line = 4; slv_auto_eoi = 1; slv_rot_aeoi = 1;
        do_ack();
        chk("R11", "slv vector", vec_out, 8'h74);
        chk("R11", "slv load", slv_prio_load, 1);
        chk("R11", "slv base", slv_prio_base, 5);
        chk("R11", "slv no isr", slv_isr_set, 0);
        chk("R9", "mst isr cascade", mst_isr_set, 8'h04);
        end_ack("R11");
        idle_inputs();
    endtask

    initial begin
        t_reset();
        t_irq();
        t_pulse();
        t_plain();
        t_level();
        t_mst_spur();
        t_cascade();
        t_casc_spur();
        t_aeoi();
        t_rotate();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule